// File: doc/BRIEF.md
# Microcoded Bus Datapath Slice

This block is the register datapath of a small microprogrammed stack machine. It acts on one wide control word in every clock cycle. One source register is placed on a 32-bit right-operand bus. The holding register H is the left operand of an ALU. The ALU result passes through a shifter to a result bus, and any set of destination registers can capture that result at the next rising edge. The block also registers a sign flag and a zero flag taken from the ALU output. A sequencer can branch on these flags.

The block does not fetch, order or decode control words, and it has no memory port. A memory subsystem returns data to the block through two input channels: a 32-bit word for the memory data register and a byte for the memory byte register. Each channel has a valid strobe and no ready signal. The datapath accepts a beat in every cycle, so it never applies back-pressure. A word beat always overrides a result-bus write to the same register in that cycle. Every register value is brought out on its own output so the surrounding machine can observe it.

Top module: `ubus_datapath`

## Requirements
- R1: While rst_n is low, every register output, n_flag and z_flag are zero.
- R2: b_sel is one-hot. The bit positions select the right operand as follows: bit 0 = MDR, 1 = PC, 2 = MBR zero-extended, 3 = MBR sign-extended, 4 = SP, 5 = LV, 6 = CPP, 7 = TOS, 8 = OPC.
- R3: If b_sel has no bit set, or more than one bit set, the right operand is zero.
- R4: alu_ctl bit 3 gates H onto the left operand (otherwise 0). Bit 1 then inverts that operand. Bit 2 gates the right operand (otherwise 0). Bits [5:4] choose the function: 00 AND, 01 OR, 10 NOT of the right operand, 11 sum of both operands plus bit 0. Bit 0 affects only the sum.
- R5: alu_ctl bit 7 shifts the ALU result left by 8 with zero fill. Bit 6 shifts it right by 1 arithmetically. If both bits are set, the result is not shifted.
- R6: c_en bit positions pick destinations: bit 0 = MAR, 1 = MDR, 2 = PC, 3 = SP, 4 = LV, 5 = CPP, 6 = TOS, 7 = OPC, 8 = H. Every enabled register captures the shifter output at the rising edge. Every register that is not enabled keeps its value.
- R7: At each rising edge, n_flag takes bit 31 of the unshifted ALU result, and z_flag is set when that result is all zeros.
- R8: When mdr_in_valid is high, MDR captures mdr_in_data at the edge, even if c_en bit 1 is also set. The other enabled destinations still capture the result-bus value.
- R9: When mbr_in_valid is high, MBR captures mbr_in_data. MBR cannot be written from the result bus and otherwise keeps its value.
- R10: The zero-extended MBR operand has bits [31:8] clear. The sign-extended MBR operand copies MBR bit 7 into bits [31:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| c_en | input | 9 | Result-bus destination enables |
| b_sel | input | 9 | One-hot right-operand source select |
| alu_ctl | input | 8 | ALU function and shifter control |
| mdr_in_valid | input | 1 | Memory word beat present |
| mdr_in_data | input | 32 | Memory word for MDR |
| mbr_in_valid | input | 1 | Memory byte beat present |
| mbr_in_data | input | 8 | Memory byte for MBR |
| mar | output | 32 | Memory address register |
| mdr | output | 32 | Memory data register |
| pc | output | 32 | Program counter |
| mbr | output | 8 | Memory byte register |
| sp | output | 32 | Stack pointer |
| lv | output | 32 | Local variable base |
| cpp | output | 32 | Constant pool pointer |
| tos | output | 32 | Top-of-stack copy |
| opc | output | 32 | Scratch register |
| h | output | 32 | ALU left-operand holding register |
| n_flag | output | 1 | Registered sign of ALU result |
| z_flag | output | 1 | Registered zero indication of ALU result |

## Verification
All 256 ALU control codes are run against three H and TOS operand pairs. One pair has mixed bits, so AND, OR and sum give different results. One pair wraps to zero, which tests the carry input and the zero flag. The third pair has only the top bit set, which separates the arithmetic right shift from a logical one and tests the sign flag. Each of the nine operand selects is driven with distinct preloaded register values, so any misrouted source is detected. MBR bytes 0x7F and 0x80 separate zero extension from sign extension. Further stimuli cover empty and two-hot selects, writes to all destinations at once, enable-free holds and a word beat that collides with a result-bus write.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
  localparam int NUM_SRC = 9;
  localparam int NUM_DST = 9;

  // right-operand source positions
  localparam int SRC_MDR  = 0;
  localparam int SRC_PC   = 1;
  localparam int SRC_MBRU = 2;
  localparam int SRC_MBRS = 3;
  localparam int SRC_SP   = 4;
  localparam int SRC_LV   = 5;
  localparam int SRC_CPP  = 6;
  localparam int SRC_TOS  = 7;
  localparam int SRC_OPC  = 8;

  // result-bus destination positions
  localparam int DST_MAR = 0;
  localparam int DST_MDR = 1;
  localparam int DST_PC  = 2;
  localparam int DST_SP  = 3;
  localparam int DST_LV  = 4;
  localparam int DST_CPP = 5;
  localparam int DST_TOS = 6;
  localparam int DST_OPC = 7;
  localparam int DST_H   = 8;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  typedef struct packed {
    logic    shl;
    logic    shr;
    alu_fn_e fn;
    logic    use_h;
    logic    use_b;
    logic    inv_h;
    logic    carry;
  } alu_ctl_t;
endpackage

// File: rtl/ubus_bsrc.sv
module ubus_bsrc
  import ubus_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [NUM_SRC-1:0]             sel,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] words,
  input  logic [BYTE_W-1:0]              mbr,
  output logic [DATA_W-1:0]              b_bus
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [NUM_SRC-1:0][DATA_W-1:0] cand;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
    if (i == SRC_MBRU) begin : g_zx
      assign cand[i] = {{PAD_W{1'b0}}, mbr};
    end else if (i == SRC_MBRS) begin : g_sx
      assign cand[i] = {{PAD_W{mbr[BYTE_W-1]}}, mbr};
    end else begin : g_word
      assign cand[i] = words[i];
    end
  end

  logic [DATA_W-1:0] ored;
  logic              sel_ok;

  always_comb begin
    ored = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      ored = ored | (cand[i] & {DATA_W{sel[i]}});
    end
    sel_ok = $onehot(sel);
    b_bus  = sel_ok ? ored : '0;
  end

  // p_zext_upper_r10: zero-extended byte never carries upper bits
  always_comb begin
    if (sel == NUM_SRC'(1) << SRC_MBRU)
      p_zext_upper_r10: assert (b_bus[DATA_W-1:BYTE_W] == '0);
  end
endmodule

// File: rtl/ubus_alu.sv
module ubus_alu
  import ubus_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHL_AMT = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  alu_ctl_t          ctl,
  output logic [DATA_W-1:0] alu_raw,
  output logic [DATA_W-1:0] c_val
);
  logic [DATA_W-1:0] opa, opb;

  always_comb begin
    opa = ctl.use_h ? a_in : '0;
    if (ctl.inv_h) opa = ~opa;
    opb = ctl.use_b ? b_in : '0;
    unique case (ctl.fn)
      FN_AND:  alu_raw = opa & opb;
      FN_OR:   alu_raw = opa | opb;
      FN_NOTB: alu_raw = ~opb;
      FN_ADD:  alu_raw = opa + opb + DATA_W'(ctl.carry);
      default: alu_raw = '0;
    endcase
  end

  always_comb begin
    unique case ({ctl.shl, ctl.shr})
      2'b10:   c_val = alu_raw << SHL_AMT;
      2'b01:   c_val = {alu_raw[DATA_W-1], alu_raw[DATA_W-1:1]};
      default: c_val = alu_raw;
    endcase
  end
endmodule

// File: rtl/ubus_regbank.sv
module ubus_regbank
  import ubus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_DST-1:0]             c_en,
  input  logic [DATA_W-1:0]              c_val,
  input  logic [NUM_DST-1:0]             ext_en,
  input  logic [NUM_DST-1:0][DATA_W-1:0] ext_val,
  output logic [NUM_DST-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < NUM_DST; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[i] <= '0;
      else if (ext_en[i]) q[i] <= ext_val[i];
      else if (c_en[i])   q[i] <= c_val;
    end

    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_en[i] && !ext_en[i]) |=> q[i] == $past(c_val));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_en[i] && !ext_en[i]) |=> $stable(q[i]));
    p_ext_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en[i] |=> q[i] == $past(ext_val[i]));
  end
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
  import ubus_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int SHL_AMT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DST-1:0]  c_en,
  input  logic [NUM_SRC-1:0]  b_sel,
  input  logic [7:0]          alu_ctl,
  input  logic                mdr_in_valid,
  input  logic [DATA_W-1:0]   mdr_in_data,
  input  logic                mbr_in_valid,
  input  logic [BYTE_W-1:0]   mbr_in_data,
  output logic [DATA_W-1:0]   mar,
  output logic [DATA_W-1:0]   mdr,
  output logic [DATA_W-1:0]   pc,
  output logic [BYTE_W-1:0]   mbr,
  output logic [DATA_W-1:0]   sp,
  output logic [DATA_W-1:0]   lv,
  output logic [DATA_W-1:0]   cpp,
  output logic [DATA_W-1:0]   tos,
  output logic [DATA_W-1:0]   opc,
  output logic [DATA_W-1:0]   h,
  output logic                n_flag,
  output logic                z_flag
);
  logic [NUM_DST-1:0][DATA_W-1:0] q;
  logic [NUM_SRC-1:0][DATA_W-1:0] words;
  logic [NUM_DST-1:0]             ext_en;
  logic [NUM_DST-1:0][DATA_W-1:0] ext_val;
  logic [DATA_W-1:0]              b_bus, alu_raw, c_val;
  logic [BYTE_W-1:0]              mbr_q;
  logic                           n_q, z_q;

  always_comb begin
    words           = '0;
    words[SRC_MDR]  = q[DST_MDR];
    words[SRC_PC]   = q[DST_PC];
    words[SRC_SP]   = q[DST_SP];
    words[SRC_LV]   = q[DST_LV];
    words[SRC_CPP]  = q[DST_CPP];
    words[SRC_TOS]  = q[DST_TOS];
    words[SRC_OPC]  = q[DST_OPC];
    ext_en          = '0;
    ext_en[DST_MDR] = mdr_in_valid;
    ext_val          = '0;
    ext_val[DST_MDR] = mdr_in_data;
  end

  ubus_bsrc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_bsrc (
    .sel   (b_sel),
    .words (words),
    .mbr   (mbr_q),
    .b_bus (b_bus)
  );

  ubus_alu #(.DATA_W(DATA_W), .SHL_AMT(SHL_AMT)) u_alu (
    .a_in    (q[DST_H]),
    .b_in    (b_bus),
    .ctl     (alu_ctl_t'(alu_ctl)),
    .alu_raw (alu_raw),
    .c_val   (c_val)
  );

  ubus_regbank #(.DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .c_en    (c_en),
    .c_val   (c_val),
    .ext_en  (ext_en),
    .ext_val (ext_val),
    .q       (q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbr_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
    end else begin
      if (mbr_in_valid) mbr_q <= mbr_in_data;
      n_q <= alu_raw[DATA_W-1];
      z_q <= (alu_raw == '0);
    end
  end

  assign mar    = q[DST_MAR];
  assign mdr    = q[DST_MDR];
  assign pc     = q[DST_PC];
  assign sp     = q[DST_SP];
  assign lv     = q[DST_LV];
  assign cpp    = q[DST_CPP];
  assign tos    = q[DST_TOS];
  assign opc    = q[DST_OPC];
  assign h      = q[DST_H];
  assign mbr    = mbr_q;
  assign n_flag = n_q;
  assign z_flag = z_q;

  p_mbr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mbr_in_valid |=> mbr == $past(mbr_in_data));
  p_mbr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mbr_in_valid |=> $stable(mbr));
  p_zflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> z_flag == ($past(alu_raw) == '0));
  p_nflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> n_flag == $past(alu_raw[DATA_W-1]));
  p_bad_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$onehot(b_sel) && alu_ctl == 8'h34 && c_en[DST_MAR]) |=> mar == '0);
endmodule

// File: tb/ubus_datapath_test.sv
module ubus_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  c_en = '0;
  logic [8:0]  b_sel = '0;
  logic [7:0]  alu_ctl = '0;
  logic        mdr_in_valid = 1'b0;
  logic [31:0] mdr_in_data = '0;
  logic        mbr_in_valid = 1'b0;
  logic [7:0]  mbr_in_data = '0;
  logic [31:0] mar, mdr, pc, sp, lv, cpp, tos, opc, h;
  logic [7:0]  mbr;
  logic        n_flag, z_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ubus_datapath uut (
    .clk(clk), .rst_n(rst_n), .c_en(c_en), .b_sel(b_sel), .alu_ctl(alu_ctl),
    .mdr_in_valid(mdr_in_valid), .mdr_in_data(mdr_in_data),
    .mbr_in_valid(mbr_in_valid), .mbr_in_data(mbr_in_data),
    .mar(mar), .mdr(mdr), .pc(pc), .mbr(mbr), .sp(sp), .lv(lv), .cpp(cpp),
    .tos(tos), .opc(opc), .h(h), .n_flag(n_flag), .z_flag(z_flag)
  );

  localparam logic [7:0] PASS_B = 8'h34;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] dst_val(input int i);
    case (i)
      0: return mar;  1: return mdr;  2: return pc;
      3: return sp;   4: return lv;   5: return cpp;
      6: return tos;  7: return opc;  default: return h;
    endcase
  endfunction

  function automatic logic [31:0] src_val(input int s);
    case (s)
      0: return mdr;
      1: return pc;
      2: return {24'h0, mbr};
      3: return {{24{mbr[7]}}, mbr};
      4: return sp;  5: return lv;  6: return cpp;  7: return tos;
      default: return opc;
    endcase
  endfunction

  function automatic logic [31:0] alu_ref(input logic [31:0] hv, bv, input logic [7:0] c);
    logic [31:0] a, b;
    a = c[3] ? hv : 32'h0;
    if (c[1]) a = ~a;
    b = c[2] ? bv : 32'h0;
    case (c[5:4])
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   return ~b;
      default: return a + b + {31'h0, c[0]};
    endcase
  endfunction

  function automatic logic [31:0] shf_ref(input logic [31:0] v, input logic [7:0] c);
    if (c[7] && !c[6]) return v << 8;
    if (c[6] && !c[7]) return $signed(v) >>> 1;
    return v;
  endfunction

  // apply controls at a falling edge, let one rising edge pass, then idle
  task automatic step(input logic [8:0] ce, input logic [8:0] bs, input logic [7:0] ac);
    c_en = ce; b_sel = bs; alu_ctl = ac;
    @(negedge clk);
    c_en = '0; b_sel = '0; alu_ctl = '0;
    mdr_in_valid = 1'b0; mbr_in_valid = 1'b0;
  endtask

  task automatic write_reg(input int idx, input logic [31:0] v);
    mdr_in_valid = 1'b1; mdr_in_data = v;
    step('0, '0, 8'h0);
    step(9'(1 << idx), 9'(1 << 0), PASS_B);
  endtask

  task automatic load_mbr(input logic [7:0] v);
    mbr_in_valid = 1'b1; mbr_in_data = v;
    step('0, '0, 8'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pre [9];
    logic [31:0] hv, bv, r, exp_v;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 9; i++) check("R1 reset reg", dst_val(i), 0);
    check("R1 reset mbr", mbr, 0);
    check("R1 reset flags", {n_flag, z_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6/R8 preload distinct values (MDR last: it is the staging register)
    for (int i = 0; i < 9; i++) pre[i] = 32'h1111_0000 * (i + 1) + 32'h0000_0F03 * i + 32'h5;
    for (int i = 0; i < 9; i++) if (i != 1) write_reg(i, pre[i]);
    write_reg(1, pre[1]);
    for (int i = 0; i < 9; i++) check("R6 preload", dst_val(i), pre[i]);
    load_mbr(8'hA5);
    check("R9 mbr load", mbr, 8'hA5);

    // R2/R10 each source routed to MAR
    for (int s = 0; s < 9; s++) begin
      exp_v = src_val(s);
      step(9'(1 << 0), 9'(1 << s), PASS_B);
      check("R2 source route", mar, exp_v);
    end
    foreach (pre[i]) ;
    load_mbr(8'h7F);
    step(9'(1 << 0), 9'(1 << 3), PASS_B);
    check("R10 sext 7F", mar, 32'h0000_007F);
    load_mbr(8'h80);
    step(9'(1 << 0), 9'(1 << 3), PASS_B);
    check("R10 sext 80", mar, 32'hFFFF_FF80);
    step(9'(1 << 0), 9'(1 << 2), PASS_B);
    check("R10 zext 80", mar, 32'h0000_0080);

    // R3 empty and two-hot selects
    write_reg(0, 32'hDEAD_BEEF);
    step(9'(1 << 0), 9'h000, PASS_B);
    check("R3 empty select", {mar, n_flag, z_flag}, {32'h0, 1'b0, 1'b1});
    write_reg(0, 32'hDEAD_BEEF);
    step(9'(1 << 0), 9'h090, PASS_B);
    check("R3 two-hot select", {mar, n_flag, z_flag}, {32'h0, 1'b0, 1'b1});

    // R4/R5/R7 every control code over three operand pairs, B = TOS
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: begin hv = 32'h8000_00F1; bv = 32'h1234_5678; end
        1: begin hv = 32'hFFFF_FFFF; bv = 32'h0000_0001; end
        default: begin hv = 32'h0000_0000; bv = 32'h8000_0000; end
      endcase
      write_reg(8, hv);
      write_reg(6, bv);
      for (int c = 0; c < 256; c++) begin
        r = alu_ref(hv, bv, 8'(c));
        step(9'(1 << 0), 9'(1 << 7), 8'(c));
        check("R4 R5 R7 alu/shift/flags", {mar, n_flag, z_flag},
              {shf_ref(r, 8'(c)), r[31], r == 32'h0});
      end
    end

    // R6 all destinations at once, R9 MBR untouched by result bus
    load_mbr(8'hC3);
    step(9'h1FF, 9'(1 << 3), PASS_B);
    for (int i = 0; i < 9; i++) check("R6 multi-dest", dst_val(i), 32'hFFFF_FFC3);
    check("R9 mbr not a destination", mbr, 8'hC3);

    // R6 hold: no enables, busy ALU
    for (int i = 0; i < 9; i++) pre[i] = dst_val(i);
    step('0, 9'(1 << 1), 8'h3F);
    for (int i = 0; i < 9; i++) check("R6 hold", dst_val(i), pre[i]);

    // R8 word beat collides with result-bus write to MDR
    write_reg(7, 32'h0BAD_F00D);
    mdr_in_valid = 1'b1; mdr_in_data = 32'h1357_9BDF;
    step(9'b0_0000_0011, 9'(1 << 8), PASS_B);
    check("R8 beat wins mdr", mdr, 32'h1357_9BDF);
    check("R8 mar still written", mar, 32'h0BAD_F00D);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule